// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This unit collects the event flags of an I2C master controller and turns them into one interrupt request. The bus engine and the FIFOs report events as single-cycle pulses. Each pulse sets a sticky flag, which stays set until software clears it. A separate enable register selects which flags may drive the interrupt line. The bus-busy bit is not sticky: it shows the live state of the bus engine.

There are two ways to clear flags, and software may use either one. The first is a write-one-to-clear write to the status register. The second is a read of the vector register. That read returns the code of the highest-priority pending event among the five oldest event kinds, and the same read clears that one flag. Access is through a simple single-cycle register port: the read data is combinational, and a write or a clearing read takes effect at the next rising clock edge.

Top module: `i2c_irq_unit`

## Requirements
- R1: After reset, the status register, the enable register, the vector register and `irq_o` all read as zero.
- R2: A pulse on `evt_i[b]` sets status bit b from the next cycle, for these positions: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 8 general-call address, 9 addressed as slave, 10 transmit underflow, 11 receive overrun, 13 receive drain, 14 transmit drain.
- R3: A write to the status register (address 0) clears each sticky bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: Status bit 12 always equals the `bus_busy_i` input. No write can change it.
- R5: If an event pulse and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R6: The enable register (address 1) stores only bits 0-4, 13 and 14. Its other bits read as 0.
- R7: `irq_o` is high exactly while some status bit is set and its enable bit is also set. Status bits that have no enable bit never raise `irq_o`, and neither does bus busy.
- R8: A read of the vector register (address 2) returns 0 when none of status bits 0-4 is set. Otherwise it returns b+1, where b is the lowest set bit among 0-4. So the codes are 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready and 5 transmit ready, and a lower code wins.
- R9: A vector read that returns a nonzero code clears only the status bit it reports. A read that returns 0 changes nothing.
- R10: If an event pulse sets the bit that a vector read reports in the same cycle, the bit stays set.
- R11: Status positions 5-7 and 15 always read as 0, and event pulses on those positions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | Single-cycle event pulses, one per status position |
| bus_busy_i | input | 1 | Live bus-busy level from the bus engine |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 2 | Register select: 0 status, 1 enable, 2 vector |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the selected register; 0 when idle |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives several patterns into the flags:
- **All events in one cycle.** This separates the implemented positions from the unused ones.
- **Clears with mixed write data.** These show that a 1 clears a flag and a 0 leaves it alone.
- **Collisions.** An event arrives in the same cycle as a write clear or a vector clear; this shows whether set or clear wins.

For the vector, groups of flags are set together and the register is read repeatedly. The codes must come out in ascending order and each read must remove only the flag it reported. This tells a correct priority order apart from a reversed one, and a single-bit clear apart from a clear of the whole group. The interrupt line is checked in every cycle. The checks use flags that have no enable bit, the live busy level, and enable patterns that cover some set flags and miss others.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 2;

  localparam int unsigned BIT_BUSY = 12;

  // sticky status positions and enable-capable positions
  localparam logic [REG_W-1:0] STICKY_MASK = 16'h6F1F;
  localparam logic [REG_W-1:0] ENABLE_MASK = 16'h601F;

  typedef enum logic [ADDR_W-1:0] {
    ADR_STAT = 2'd0,
    ADR_MASK = 2'd1,
    ADR_VEC  = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic rd_stat;
    logic wr_stat;
    logic rd_mask;
    logic wr_mask;
    logic rd_vec;
  } acc_t;
endpackage

// File: rtl/i2c_irq_regif.sv
module i2c_irq_regif
  import i2c_irq_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  stat_i,
  input  logic [W-1:0]  mask_i,
  input  logic [W-1:0]  vec_i,
  output acc_t          acc_o,
  output logic [W-1:0]  rdata_o
);
  always_comb begin
    acc_o = '0;
    if (req_i) begin
      unique case (addr_i)
        ADR_STAT: begin acc_o.wr_stat = we_i;  acc_o.rd_stat = !we_i; end
        ADR_MASK: begin acc_o.wr_mask = we_i;  acc_o.rd_mask = !we_i; end
        ADR_VEC:  acc_o.rd_vec = !we_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (acc_o.rd_stat) rdata_o = stat_i;
    if (acc_o.rd_mask) rdata_o = mask_i;
    if (acc_o.rd_vec)  rdata_o = vec_i;
  end
endmodule

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags #(
  parameter int unsigned    W    = 16,
  parameter logic [W-1:0]   IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL[b]) begin : g_ff
      logic bit_q;
      // set has priority over clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        bit_q <= 1'b0;
        else if (set_i[b])  bit_q <= 1'b1;
        else if (clr_i[b])  bit_q <= 1'b0;
      end
      assign q_o[b] = bit_q;
    end else begin : g_tie
      assign q_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/i2c_irq_prio.sv
module i2c_irq_prio #(
  parameter int unsigned N      = 5,
  localparam int unsigned CODE_W = $clog2(N + 1)
) (
  input  logic [N-1:0]      src_i,
  output logic [CODE_W-1:0] code_o,
  output logic [N-1:0]      hit_o
);
  // lowest index wins
  always_comb begin
    code_o = '0;
    hit_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (src_i[i]) begin
        code_o   = CODE_W'(i + 1);
        hit_o    = '0;
        hit_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
  import i2c_irq_pkg::*;
#(
  parameter int unsigned VEC_N = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  evt_i,
  input  logic              bus_busy_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int unsigned CODE_W = $clog2(VEC_N + 1);

  acc_t             acc;
  logic [REG_W-1:0] st_q, en_q, stat_view, vec_view;
  logic [REG_W-1:0] set_v, clr_v, vec_clr;
  logic [CODE_W-1:0] vec_code;
  logic [VEC_N-1:0]  vec_hit;

  i2c_irq_regif #(.W(REG_W), .AW(ADDR_W)) u_regif (
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .stat_i  (stat_view),
    .mask_i  (en_q),
    .vec_i   (vec_view),
    .acc_o   (acc),
    .rdata_o (rdata_o)
  );

  i2c_irq_prio #(.N(VEC_N)) u_prio (
    .src_i  (st_q[VEC_N-1:0]),
    .code_o (vec_code),
    .hit_o  (vec_hit)
  );

  always_comb begin
    vec_clr = '0;
    if (acc.rd_vec) vec_clr[VEC_N-1:0] = vec_hit;
  end

  assign set_v = evt_i & STICKY_MASK;
  assign clr_v = (acc.wr_stat ? wdata_i : '0) | vec_clr;

  i2c_irq_flags #(.W(REG_W), .IMPL(STICKY_MASK)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .q_o    (st_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          en_q <= '0;
    else if (acc.wr_mask) en_q <= wdata_i & ENABLE_MASK;
  end

  always_comb begin
    stat_view = st_q;
    stat_view[BIT_BUSY] = bus_busy_i;
  end

  assign vec_view = REG_W'(vec_code);
  assign irq_o    = |(st_q & en_q);
endmodule

// File: rtl/i2c_irq_unit_chk.sv
module i2c_irq_unit_chk
  import i2c_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_W-1:0]  evt_i,
  input logic              bus_busy_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              irq_o,
  input logic [REG_W-1:0]  st_q
);
  logic wr_st, wr_en, rd_st, rd_vec;
  assign wr_st  = req_i && we_i  && (addr_i == ADR_STAT);
  assign wr_en  = req_i && we_i  && (addr_i == ADR_MASK);
  assign rd_st  = req_i && !we_i && (addr_i == ADR_STAT);
  assign rd_vec = req_i && !we_i && (addr_i == ADR_VEC);

  assert_evt_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_i & STICKY_MASK)) |=>
      ((st_q & $past(evt_i & STICKY_MASK)) == $past(evt_i & STICKY_MASK)));

  assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_st |=> ((st_q & $past(wdata_i & ~evt_i)) == '0));

  assert_busy_live_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_st |-> (rdata_o[BIT_BUSY] == bus_busy_i));

  assert_unused_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_st |-> ((rdata_o & 16'h80E0) == '0));

  assert_vec_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vec |-> (rdata_o <= 16'd5));

  assert_vec_one_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vec && (|st_q[4:0]) && !(|evt_i[4:0])) |=>
      ($countones(st_q[4:0]) + 1 == $countones($past(st_q[4:0]))));

  assert_irq_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((|evt_i) || wr_en));
endmodule

bind i2c_irq_unit i2c_irq_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .bus_busy_i (bus_busy_i),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .st_q       (st_q)
);

// File: tb/sim_i2c_irq_unit.sv
module sim_i2c_irq_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] evt_i = '0;
  logic        bus_busy_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  i2c_irq_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .bus_busy_i(bus_busy_i),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #10 clk_i = ~clk_i;

  typedef struct {
    logic        rd;
    logic [15:0] d;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t q[$];
  event smp_ev;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 0;

  logic [15:0] m_flags = '0, m_en = '0;

  localparam logic [15:0] STICKY = 16'h6F1F;
  localparam logic [15:0] ENM    = 16'h601F;

  function automatic int vcode(logic [15:0] f);
    for (int i = 0; i < 5; i++) if (f[i]) return i + 1;
    return 0;
  endfunction

  // monitor
  initial begin
    forever begin
      @(smp_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (irq_o !== e.irq) begin
          n_bad++;
          $display("FAIL %s irq: actual %b expected %b", e.tag, irq_o, e.irq);
        end
        if (e.rd) begin
          n_cmp++;
          if (rdata_o !== e.d) begin
            n_bad++;
            $display("FAIL %s rdata: actual %h expected %h", e.tag, rdata_o, e.d);
          end
        end
      end
    end
  end

  // driver: one cycle of stimulus with expectation
  task automatic op(input logic [15:0] evt, input logic busy, input logic rq,
                    input logic we, input logic [1:0] adr, input logic [15:0] wd,
                    input string tag);
    exp_t e;
    int   code;
    logic [15:0] clr;
    @(negedge clk_i);
    evt_i = evt; bus_busy_i = busy; req_i = rq; we_i = we; addr_i = adr; wdata_i = wd;
    #5;
    code  = vcode(m_flags);
    e.rd  = rq && !we;
    e.irq = |(m_flags & m_en);
    e.tag = tag;
    e.d   = '0;
    if (e.rd) begin
      case (adr)
        2'd0: e.d = m_flags | (16'(busy) << 12);
        2'd1: e.d = m_en;
        2'd2: e.d = 16'(code);
        default: e.d = '0;
      endcase
    end
    q.push_back(e);
    -> smp_ev;
    @(posedge clk_i);
    if (rst_ni) begin
      clr = '0;
      if (rq && we && adr == 2'd0) clr = wd;
      if (rq && !we && adr == 2'd2 && code != 0) clr[code-1] = 1'b1;
      m_flags = ((m_flags & ~clr) | evt) & STICKY;
      if (rq && we && adr == 2'd1) m_en = wd & ENM;
    end
  endtask

  task automatic rd(input logic [1:0] adr, input logic busy, input string tag);
    op('0, busy, 1'b1, 1'b0, adr, '0, tag);
  endtask
  task automatic wr(input logic [1:0] adr, input logic [15:0] wd, input string tag);
    op('0, 1'b0, 1'b1, 1'b1, adr, wd, tag);
  endtask
  task automatic ev(input logic [15:0] evt, input string tag);
    op(evt, 1'b0, 1'b0, 1'b0, 2'd0, '0, tag);
  endtask

  initial begin
    // R1 reset
    rd(2'd0, 1'b0, "R1 status in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    rd(2'd0, 1'b0, "R1 status after reset");
    rd(2'd1, 1'b0, "R1 enable after reset");
    rd(2'd2, 1'b0, "R1 vector after reset");

    // R2 R11 all events
    ev(16'hFFFF, "R2 all pulses");
    rd(2'd0, 1'b0, "R2 R11 status after all pulses");
    // R4 busy live, R3 clear all
    rd(2'd0, 1'b1, "R4 busy visible");
    wr(2'd0, 16'hFFFF, "R3 clear all");
    rd(2'd0, 1'b1, "R4 busy survives write");
    rd(2'd0, 1'b0, "R4 busy dropped");

    // R3 zero keeps
    ev(16'h0C03, "R2 pulses");
    wr(2'd0, 16'h0000, "R3 write zero");
    rd(2'd0, 1'b0, "R3 zero keeps bits");
    wr(2'd0, 16'h0801, "R3 partial clear");
    rd(2'd0, 1'b0, "R3 partial clear result");

    // R5 collision
    op(16'h0002, 1'b0, 1'b1, 1'b1, 2'd0, 16'h0402, "R5 set and clear same cycle");
    rd(2'd0, 1'b0, "R5 set wins");
    wr(2'd0, 16'hFFFF, "R3 clear all");

    // R6 enable mask
    wr(2'd1, 16'hFFFF, "R6 write enable");
    rd(2'd1, 1'b0, "R6 enable readback");

    // R7 irq
    ev(16'h0F00, "R7 non-enableable events");
    op('0, 1'b1, 1'b0, 1'b0, 2'd0, '0, "R7 busy no irq");
    ev(16'h2000, "R7 drain event");
    ev(16'h0000, "R7 irq high");
    wr(2'd0, 16'h2000, "R7 clear drain");
    ev(16'h0010, "R7 tx ready event");
    wr(2'd1, 16'h0001, "R7 enable other bit");
    wr(2'd1, 16'h0010, "R7 enable matching bit");
    ev(16'h0000, "R7 irq high again");
    wr(2'd1, 16'h0000, "R7 enable off");
    wr(2'd0, 16'hFFFF, "R3 clear all");

    // R8 R9 vector order
    ev(16'h0F15, "R8 set 0 2 4 plus others");
    rd(2'd2, 1'b0, "R8 vector code 1");
    rd(2'd0, 1'b0, "R9 only bit 0 cleared");
    rd(2'd2, 1'b0, "R8 vector code 3");
    rd(2'd2, 1'b0, "R8 vector code 5");
    rd(2'd2, 1'b0, "R8 vector empty");
    rd(2'd0, 1'b0, "R9 zero read keeps status");
    ev(16'h000A, "R8 set 1 3");
    rd(2'd2, 1'b0, "R8 vector code 2");
    rd(2'd2, 1'b0, "R8 vector code 4");
    rd(2'd2, 1'b0, "R8 vector empty again");

    // R10 vector clear collision
    ev(16'h0004, "R10 set access ready");
    op(16'h0004, 1'b0, 1'b1, 1'b0, 2'd2, '0, "R10 read with event");
    rd(2'd2, 1'b0, "R10 bit still set");
    rd(2'd2, 1'b0, "R10 now empty");

    // R11 ignored positions with irq enabled
    wr(2'd1, 16'hFFFF, "R11 enable all");
    ev(16'h80E0, "R11 unused pulses");
    rd(2'd0, 1'b0, "R11 unused stay zero");
    ev(16'h0000, "R11 irq stays low");

    done = 1;
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule